// File: doc/BRIEF.md
# Programmable Serial Audio Port Router

This block is a configurable crossbar for synchronous serial audio, voice and data links. It connects two classes of port. Host ports face on-chip serial controllers and always use six wires: a transmit clock, a transmit frame sync and transmit data, plus a receive clock, a receive frame sync and receive data. Peripheral ports face off-chip codecs or other processors. Each peripheral port can run as a six-wire asynchronous link or as a four-wire synchronous link, where one clock and one frame sync serve both directions.

Software sets up one configuration word for each destination port. The word chooses which port's transmit data drives this port's receive data, and which port supplies its timing (clocks and frame syncs). It also sets whether the port drives its clock pins and its frame-sync pins or leaves them as inputs. Any port can feed any number of destinations, so point-to-point and one-to-many (network) flows can run at the same time. A port that selects itself loops its own transmit data back into its receive data, which is useful for test.

The configuration is held in registers. The serial paths are purely combinational, so routing adds no cycle of latency to the audio signals. There is no data stream with flow control at the edges: the serial lines are raw wires and the configuration port is a plain write strobe, so nothing applies back-pressure.

Top module: `sar_router`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, every port is disabled: all data, clock and frame-sync outputs and all four output-enable vectors are 0.
- R2: When cfg_we is 1 at a rising clock edge, cfg_wdata is stored for port cfg_idx, and the new routing is visible right after that edge. The word layout is: bit 0 enable, bit 1 four-wire synchronous mode, bit 2 drive clocks, bit 3 drive frame syncs, bits [4+SW-1:4] data source, bits [4+2*SW-1:4+SW] timing source. When cfg_we is 0, no configuration changes.
- R3: A write whose cfg_idx is NP or greater changes no port.
- R4: For an enabled port p with data source s, rxd_o[p] equals txd_i[s] in the same cycle. When s equals p, this gives loopback.
- R5: One source can drive the receive data of several destination ports at the same time.
- R6: A data or timing source index of NP or greater selects nothing, so the routed value is 0.
- R7: In six-wire mode, with timing source t: txc_o[p] and txfs_o[p] follow rxc_i[t] and rxfs_i[t], and rxc_o[p] and rxfs_o[p] follow txc_i[t] and txfs_i[t].
- R8: The drive-clocks bit sets both txc_oe[p] and rxc_oe[p]. The drive-frame-syncs bit sets both txfs_oe[p] and rxfs_oe[p]. The two bits are independent of each other. A clock or frame-sync output whose enable is low reads 0.
- R9: A peripheral port in four-wire synchronous mode drives its receive clock and frame sync with the same values as its transmit clock and frame sync. Both come from rxc_i[t] and rxfs_i[t] of the timing source t.
- R10: Host ports (index below N_HOST) ignore the four-wire bit and always behave as in R7.
- R11: A disabled port outputs 0 on rxd_o and on all its clock and frame-sync outputs, and keeps all its output enables low, whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | SW | Index of the port to write |
| cfg_wdata | input | 4+2*SW | Configuration word (layout in R2) |
| txd_i | input | NP | Transmit data arriving from each port |
| txc_i | input | NP | Transmit clock arriving from each port |
| txfs_i | input | NP | Transmit frame sync arriving from each port |
| rxc_i | input | NP | Receive clock arriving from each port |
| rxfs_i | input | NP | Receive frame sync arriving from each port |
| rxd_o | output | NP | Routed receive data to each port |
| txc_o | output | NP | Routed transmit clock to each port |
| txfs_o | output | NP | Routed transmit frame sync to each port |
| rxc_o | output | NP | Routed receive clock to each port |
| rxfs_o | output | NP | Routed receive frame sync to each port |
| txc_oe | output | NP | Output enable for txc_o |
| txfs_oe | output | NP | Output enable for txfs_o |
| rxc_oe | output | NP | Output enable for rxc_o |
| rxfs_oe | output | NP | Output enable for rxfs_o |

## Verification
The block produces results with two different delays. A change on any serial input must appear on the routed outputs in the same cycle, with no clock edge in between. A configuration write must show its effect right after the single rising edge that captures it. The bench therefore drives inputs and write strobes on falling edges. It then waits one nanosecond, well before the next rising edge, and compares every output of every port with a model of the stored configuration. Serial-input checks thus show that nothing is registered on the data path. Write checks show that exactly one edge separates a write from its effect.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // Per-port control flags; bit 0 is the enable.
  localparam int FLAG_W = 4;

  typedef struct packed {
    logic fs_out;   // drive frame syncs
    logic clk_out;  // drive clocks
    logic sync4;    // four-wire synchronous mode
    logic en;       // port enable
  } port_flags_t;

  function automatic int sel_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sar_cfg_regs.sv
module sar_cfg_regs
  import sar_pkg::*;
#(
  parameter int NP   = 7,
  parameter int NH   = 3,
  parameter int SW   = sel_width(NP),
  parameter int WD   = FLAG_W + 2 * SW
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [SW-1:0]              idx,
  input  logic [WD-1:0]              wdata,
  output port_flags_t [NP-1:0]       flags_o,
  output logic [NP-1:0][SW-1:0]      dsel_o,
  output logic [NP-1:0][SW-1:0]      csel_o
);

  localparam int DS_LO = FLAG_W;
  localparam int CS_LO = FLAG_W + SW;

  logic [SW-1:0] w_dsel;
  logic [SW-1:0] w_csel;
  assign w_dsel = wdata[DS_LO +: SW];
  assign w_csel = wdata[CS_LO +: SW];

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic hit;
    logic sync_bit;
    assign hit = we && (int'(idx) == p);

    if (p < NH) begin : g_host
      assign sync_bit = 1'b0;
    end else begin : g_periph
      assign sync_bit = wdata[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags_o[p] <= '0;
        dsel_o[p]  <= '0;
        csel_o[p]  <= '0;
      end else if (hit) begin
        flags_o[p].en      <= wdata[0];
        flags_o[p].sync4   <= sync_bit;
        flags_o[p].clk_out <= wdata[2];
        flags_o[p].fs_out  <= wdata[3];
        dsel_o[p]          <= w_dsel;
        csel_o[p]          <= w_csel;
      end
    end
  end

  // R2: without a write strobe the stored configuration holds
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(flags_o) && $stable(dsel_o) && $stable(csel_o)));

  // R3: an out-of-range index leaves every port untouched
  a_r3_bad_index_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(idx) >= NP) |=> ($stable(flags_o) && $stable(dsel_o) && $stable(csel_o)));

endmodule

// File: rtl/sar_port_mux.sv
module sar_port_mux
  import sar_pkg::*;
#(
  parameter int NP      = 7,
  parameter int SW      = sel_width(NP),
  parameter bit IS_HOST = 1'b1
) (
  input  port_flags_t    flags,
  input  logic [SW-1:0]  dsel,
  input  logic [SW-1:0]  csel,
  input  logic [NP-1:0]  txd_i,
  input  logic [NP-1:0]  txc_i,
  input  logic [NP-1:0]  txfs_i,
  input  logic [NP-1:0]  rxc_i,
  input  logic [NP-1:0]  rxfs_i,
  output logic           rxd,
  output logic           txc,
  output logic           txfs,
  output logic           rxc,
  output logic           rxfs,
  output logic           txc_oe,
  output logic           txfs_oe,
  output logic           rxc_oe,
  output logic           rxfs_oe
);

  logic d_ok, c_ok;
  logic src_txd, src_txc, src_txfs, src_rxc, src_rxfs;
  logic sync_eff, clk_on, fs_on;

  assign d_ok = int'(dsel) < NP;
  assign c_ok = int'(csel) < NP;

  assign src_txd  = d_ok ? txd_i[dsel]  : 1'b0;
  assign src_txc  = c_ok ? txc_i[csel]  : 1'b0;
  assign src_txfs = c_ok ? txfs_i[csel] : 1'b0;
  assign src_rxc  = c_ok ? rxc_i[csel]  : 1'b0;
  assign src_rxfs = c_ok ? rxfs_i[csel] : 1'b0;

  if (IS_HOST) begin : g_six_only
    assign sync_eff = 1'b0;
  end else begin : g_selectable
    assign sync_eff = flags.sync4;
  end

  assign clk_on = flags.en & flags.clk_out;
  assign fs_on  = flags.en & flags.fs_out;

  assign rxd     = flags.en & src_txd;
  assign txc     = clk_on & src_rxc;
  assign txfs    = fs_on & src_rxfs;
  assign rxc     = clk_on & (sync_eff ? src_rxc  : src_txc);
  assign rxfs    = fs_on  & (sync_eff ? src_rxfs : src_txfs);
  assign txc_oe  = clk_on;
  assign rxc_oe  = clk_on;
  assign txfs_oe = fs_on;
  assign rxfs_oe = fs_on;

endmodule

// File: rtl/sar_router.sv
module sar_router
  import sar_pkg::*;
#(
  parameter int N_HOST   = 3,
  parameter int N_PERIPH = 4,
  localparam int NP = N_HOST + N_PERIPH,
  localparam int SW = sel_width(NP),
  localparam int WD = FLAG_W + 2 * SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_idx,
  input  logic [WD-1:0] cfg_wdata,
  input  logic [NP-1:0] txd_i,
  input  logic [NP-1:0] txc_i,
  input  logic [NP-1:0] txfs_i,
  input  logic [NP-1:0] rxc_i,
  input  logic [NP-1:0] rxfs_i,
  output logic [NP-1:0] rxd_o,
  output logic [NP-1:0] txc_o,
  output logic [NP-1:0] txfs_o,
  output logic [NP-1:0] rxc_o,
  output logic [NP-1:0] rxfs_o,
  output logic [NP-1:0] txc_oe,
  output logic [NP-1:0] txfs_oe,
  output logic [NP-1:0] rxc_oe,
  output logic [NP-1:0] rxfs_oe
);

  port_flags_t [NP-1:0]  flags;
  logic [NP-1:0][SW-1:0] dsel;
  logic [NP-1:0][SW-1:0] csel;

  sar_cfg_regs #(.NP(NP), .NH(N_HOST), .SW(SW), .WD(WD)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .idx     (cfg_idx),
    .wdata   (cfg_wdata),
    .flags_o (flags),
    .dsel_o  (dsel),
    .csel_o  (csel)
  );

  for (genvar p = 0; p < NP; p++) begin : g_route
    sar_port_mux #(.NP(NP), .SW(SW), .IS_HOST(p < N_HOST)) u_mux (
      .flags   (flags[p]),
      .dsel    (dsel[p]),
      .csel    (csel[p]),
      .txd_i   (txd_i),
      .txc_i   (txc_i),
      .txfs_i  (txfs_i),
      .rxc_i   (rxc_i),
      .rxfs_i  (rxfs_i),
      .rxd     (rxd_o[p]),
      .txc     (txc_o[p]),
      .txfs    (txfs_o[p]),
      .rxc     (rxc_o[p]),
      .rxfs    (rxfs_o[p]),
      .txc_oe  (txc_oe[p]),
      .txfs_oe (txfs_oe[p]),
      .rxc_oe  (rxc_oe[p]),
      .rxfs_oe (rxfs_oe[p])
    );

    // R11: a disabled port is silent and drives no pin
    a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !flags[p].en |-> (!rxd_o[p] && !txc_o[p] && !txfs_o[p] && !rxc_o[p] && !rxfs_o[p]
                        && !txc_oe[p] && !txfs_oe[p] && !rxc_oe[p] && !rxfs_oe[p]));

    // R8: an output enable only rises on an enabled port
    a_r8_oe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (txc_oe[p] || txfs_oe[p] || rxc_oe[p] || rxfs_oe[p]) |-> flags[p].en);

    // R8: pins left as inputs read low
    a_r8_undriven_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!txc_oe[p] |-> (!txc_o[p] && !rxc_o[p])) and (!txfs_oe[p] |-> (!txfs_o[p] && !rxfs_o[p])));

    // R6: an out-of-range data source yields a low receive line
    a_r6_no_source_low: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(dsel[p]) >= NP) |-> !rxd_o[p]);

    if (p >= N_HOST) begin : g_sync_chk
      // R9: four-wire mode shares one timing pair across directions
      a_r9_sync_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[p].en && flags[p].sync4) |-> (rxc_o[p] == txc_o[p] && rxfs_o[p] == txfs_o[p]));
    end
  end

endmodule

// File: tb/sar_router_tb.sv
module sar_router_tb;

  localparam int NH = 3;
  localparam int NPER = 4;
  localparam int NP = NH + NPER;
  localparam int SW = 3;
  localparam int WD = 4 + 2 * SW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [SW-1:0] cfg_idx = '0;
  logic [WD-1:0] cfg_wdata = '0;
  logic [NP-1:0] txd_i = '0, txc_i = '0, txfs_i = '0, rxc_i = '0, rxfs_i = '0;
  logic [NP-1:0] rxd_o, txc_o, txfs_o, rxc_o, rxfs_o;
  logic [NP-1:0] txc_oe, txfs_oe, rxc_oe, rxfs_oe;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  int m_en[NP], m_sy[NP], m_co[NP], m_fo[NP], m_ds[NP], m_cs[NP];

  always #5 clk = ~clk;

  sar_router #(.N_HOST(NH), .N_PERIPH(NPER)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .txd_i(txd_i), .txc_i(txc_i), .txfs_i(txfs_i), .rxc_i(rxc_i), .rxfs_i(rxfs_i),
    .rxd_o(rxd_o), .txc_o(txc_o), .txfs_o(txfs_o), .rxc_o(rxc_o), .rxfs_o(rxfs_o),
    .txc_oe(txc_oe), .txfs_oe(txfs_oe), .rxc_oe(rxc_oe), .rxfs_oe(rxfs_oe)
  );

  function automatic logic pick(input logic [NP-1:0] v, input int i);
    return (i < NP) ? v[i] : 1'b0;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  // Compare every port's nine outputs with the model (sampled 1 ns after a falling edge)
  task automatic check_all(input string req);
    for (int p = 0; p < NP; p++) begin
      logic [8:0] act, exp;
      logic e, co, fo, sy;
      e  = m_en[p][0];
      co = e & m_co[p][0];
      fo = e & m_fo[p][0];
      sy = m_sy[p][0] & (p >= NH);
      exp[0] = e & pick(txd_i, m_ds[p]);
      exp[1] = co & pick(rxc_i, m_cs[p]);
      exp[2] = fo & pick(rxfs_i, m_cs[p]);
      exp[3] = co & (sy ? pick(rxc_i, m_cs[p]) : pick(txc_i, m_cs[p]));
      exp[4] = fo & (sy ? pick(rxfs_i, m_cs[p]) : pick(txfs_i, m_cs[p]));
      exp[5] = co; exp[6] = fo; exp[7] = co; exp[8] = fo;
      act = {rxfs_oe[p], rxc_oe[p], txfs_oe[p], txc_oe[p],
             rxfs_o[p], rxc_o[p], txfs_o[p], txc_o[p], rxd_o[p]};
      n_checks++;
      if (act !== exp) begin
        n_fails++;
        $display("FAIL %s port %0d: actual %b expected %b", req, p, act, exp);
      end
    end
  endtask

  task automatic set_in(input int k);
    @(negedge clk);
    txd_i  = NP'(k * 37 + 11);
    txc_i  = NP'(k * 53 + 3);
    txfs_i = NP'(k * 29 + 90);
    rxc_i  = NP'(k * 71 + 45);
    rxfs_i = NP'(k * 19 + 100);
    #1;
  endtask

  task automatic wr(input int idx, input int en, input int sy, input int co, input int fo,
                    input int ds, input int cs);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_idx   = SW'(idx);
    cfg_wdata = {SW'(cs), SW'(ds), fo[0], co[0], sy[0], en[0]};
    @(posedge clk);
    if (idx < NP) begin
      m_en[idx] = en; m_sy[idx] = sy; m_co[idx] = co;
      m_fo[idx] = fo; m_ds[idx] = ds; m_cs[idx] = cs;
    end
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      m_en[p] = 0; m_sy[p] = 0; m_co[p] = 0; m_fo[p] = 0; m_ds[p] = 0; m_cs[p] = 0;
    end
    set_in(5);
    check_all("R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    set_in(6);
    check_all("R1 after reset");

    // R4 R6 R7 R2: every destination against every source index, loopback included
    for (int d = 0; d < NP; d++) begin
      for (int s = 0; s < 8; s++) begin
        wr(d, 1, 0, 1, 1, s, 7 - s);
        check_all("R2 R4 R6 R7 routing");
        for (int k = 0; k < 3; k++) begin
          set_in(d * 8 + s + k);
          check_all("R4 R6 R7 routing");
        end
      end
    end

    // R5: one source fans out to every port
    for (int p = 0; p < NP; p++) wr(p, 1, 0, 1, 1, 2, 4);
    for (int k = 0; k < 6; k++) begin
      set_in(100 + k);
      check_all("R5 fan-out");
    end

    // R8: clock and frame-sync directions, all combinations
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 4; m++) begin
        wr(p, 1, 0, m & 1, (m >> 1) & 1, p, (p + 1) % NP);
        set_in(200 + p * 4 + m);
        check_all("R8 direction");
      end
    end

    // R9 R10: four-wire bit set on every port
    for (int p = 0; p < NP; p++) wr(p, 1, 1, 1, 1, 0, (p + 2) % NP);
    for (int k = 0; k < 8; k++) begin
      set_in(300 + k);
      check_all("R9 R10 sync mode");
    end

    // R11: disabled ports with busy fields
    for (int p = 0; p < NP; p += 2) wr(p, 0, 1, 1, 1, 1, 1);
    for (int k = 0; k < 4; k++) begin
      set_in(400 + k);
      check_all("R11 disabled");
    end

    // R3: write to an index past the last port
    for (int p = 0; p < NP; p++) wr(p, 1, 0, 1, 1, (p + 3) % NP, p);
    wr(7, 0, 1, 0, 0, 6, 6);
    for (int k = 0; k < 4; k++) begin
      set_in(500 + k);
      check_all("R3 bad index");
    end

    // R2: data on the write bus without the strobe
    @(negedge clk);
    cfg_idx = '0;
    cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    for (int k = 0; k < 3; k++) begin
      set_in(600 + k);
      check_all("R2 no strobe");
    end

    summary();
  end

endmodule